// File: doc/BRIEF.md
# Codec Power-State Controller

This block keeps the power-down settings of a mixed-signal audio codec and turns them into live enable lines for the converter, the serial ports and the two sample-rate converters. A single global power-down bit overrides almost everything. While it is set, every subblock is off except the clock-synthesizer run control and the S/PDIF transmitter power-down, which keep their own settings. When the bit is cleared, each subblock follows its own control bit.

The power state of each sample-rate converter is the result of a priority chain. Global power-down comes first. Next is a manual-override bit that hands control to two explicit enable bits. Without override, a bypass bit switches a converter off. After that an interface-select pin decides between "always on" and "follow the matching serial-port enable". The block also guards and sequences global power-down. A request to enter it is refused unless a supply-latch bit is already set, and a done flag reports when the serial clock may be stopped. A timed clamp discharges the reference capacitor, and it may run only while the codec is globally off.

Software reaches three 8-bit locations through a simple write strobe with a combinational read mux.

Top module: `codec_pwr_ctl`

## Requirements
- R1: After reset, location 0 reads 0x2D, location 1 reads 0x04 and status (location 2) reads 0x00 (before the done delay elapses). All enables are low and `spdif_tx_off_o` is high.
- R2: While global-off (location 0 bit 0) is 1, `adc_on_o`, `port_on_o`, `port1_on_o`, `dac_src_on_o` and `adc_src_on_o` are 0. `pll_run_o` (bit 4) and `spdif_tx_off_o` (bit 5) track their own bits. Once global-off is 0, the ADC (bit 2, 1 = off) and main port (bit 3, 1 = off) follow their bits.
- R3: A write that sets global-off while it is 0 and the latch bit (location 0 bit 1) is 0 leaves global-off at 0 and sets the sticky error (status bit 1). Writing 1 to status bit 1 clears it. With the latch bit set, the request is taken.
- R4: Done (status bit 0, `done_o`) rises DONE_CYC clock cycles after global-off becomes 1, and drops in the same cycle global-off returns to 0.
- R5: With override (location 1 bit 3) at 0, a converter whose bypass input is 1 is off, even when its port is enabled.
- R6: With override 0 and bypass 0, a high `if_sel_i` turns both converters on. A low `if_sel_i` makes the DAC converter follow `sdin0_en_i` and the ADC converter follow `sdout_en_i`.
- R7: With override 1, the DAC converter follows location 1 bit 1 and the ADC converter follows bit 0, regardless of bypass, pin and port enables.
- R8: The second port (location 1 bit 2, 1 = off) is off whenever the main port is off, and its own bit is unchanged.
- R9: The clamp bit (location 1 bit 4) is accepted only while global-off is 1. `clamp_o` then stays high exactly DIS_CYC cycles, after which the bit clears itself. Clearing global-off releases the clamp at once.
- R10: Location 0 bits 7:6, location 1 bits 7:5 and location 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe |
| addr_i | input | 2 | Location select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected location |
| bypass_dac_i | input | 1 | DAC converter bypass |
| bypass_adc_i | input | 1 | ADC converter bypass |
| if_sel_i | input | 1 | Interface-select pin level |
| sdin0_en_i | input | 1 | Serial input port 0 enabled |
| sdout_en_i | input | 1 | Serial output port enabled |
| adc_on_o | output | 1 | ADC power enable |
| port_on_o | output | 1 | Main serial port enable |
| port1_on_o | output | 1 | Second serial port enable |
| dac_src_on_o | output | 1 | DAC converter enable |
| adc_src_on_o | output | 1 | ADC converter enable |
| pll_run_o | output | 1 | Clock synthesizer run |
| spdif_tx_off_o | output | 1 | S/PDIF transmitter power-down |
| clamp_o | output | 1 | Reference capacitor clamp |
| done_o | output | 1 | Codec fully off, serial clock removable |

## Verification
The bench builds the block with CLK_HZ of 1 MHz, DISCHARGE_US of 40 and DONE_CYC of 5. This shrinks the clamp window to 40 cycles and the done delay to 5 cycles. With these values the exact rising and falling cycle of both timers can be checked, and so can an early release of the clamp partway through its window. A vector table covers the priority chain of both converters, with override, bypass, the pin and the port enables set against each other.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam logic [1:0] ADR_PWR  = 2'd0;
  localparam logic [1:0] ADR_CFG  = 2'd1;
  localparam logic [1:0] ADR_STAT = 2'd2;

  // location 0 bit positions
  localparam int B_GLOB  = 0;
  localparam int B_LATCH = 1;
  localparam int B_ADC   = 2;
  localparam int B_PORT  = 3;
  localparam int B_PLL   = 4;
  localparam int B_SPDIF = 5;
  // location 1 bit positions
  localparam int B_AEN   = 0;
  localparam int B_DEN   = 1;
  localparam int B_PORT1 = 2;
  localparam int B_OVR   = 3;
  localparam int B_CLAMP = 4;
  // status bit positions
  localparam int B_DONE  = 0;
  localparam int B_ERR   = 1;

  typedef struct packed {
    logic glob_off;
    logic latch_hold;
    logic adc_off;
    logic port_off;
    logic pll_run;
    logic spdif_off;
    logic clamp;
    logic override;
    logic port1_off;
    logic dac_en;
    logic adc_en;
    logic err;
  } pwr_ctl_t;

  localparam pwr_ctl_t CTL_RST = '{glob_off: 1'b1, latch_hold: 1'b0, adc_off: 1'b1,
                                   port_off: 1'b1, pll_run: 1'b0, spdif_off: 1'b1,
                                   clamp: 1'b0, override: 1'b0, port1_off: 1'b1,
                                   dac_en: 1'b0, adc_en: 1'b0, err: 1'b0};
endpackage

// File: rtl/pwr_regs.sv
module pwr_regs
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       done_i,
  input  logic       disch_end_i,
  output pwr_ctl_t   ctl_o,
  output logic [7:0] rdata_o
);
  pwr_ctl_t ctl_q, ctl_d;
  logic     upd;
  logic     unused_wr_hi;

  assign unused_wr_hi = ^wdata_i[7:6];
  assign upd = we_i | disch_end_i;

  always_comb begin
    ctl_d = ctl_q;
    if (disch_end_i) ctl_d.clamp = 1'b0;
    if (we_i) begin
      case (addr_i)
        ADR_PWR: begin
          ctl_d.latch_hold = wdata_i[B_LATCH];
          ctl_d.adc_off    = wdata_i[B_ADC];
          ctl_d.port_off   = wdata_i[B_PORT];
          ctl_d.pll_run    = wdata_i[B_PLL];
          ctl_d.spdif_off  = wdata_i[B_SPDIF];
          if (wdata_i[B_GLOB] && !ctl_q.glob_off && !ctl_q.latch_hold)
            ctl_d.err = 1'b1;
          else
            ctl_d.glob_off = wdata_i[B_GLOB];
          if (!ctl_d.glob_off) ctl_d.clamp = 1'b0;
        end
        ADR_CFG: begin
          ctl_d.clamp     = wdata_i[B_CLAMP] & ctl_q.glob_off;
          ctl_d.override  = wdata_i[B_OVR];
          ctl_d.port1_off = wdata_i[B_PORT1];
          ctl_d.dac_en    = wdata_i[B_DEN];
          ctl_d.adc_en    = wdata_i[B_AEN];
        end
        ADR_STAT: begin
          if (wdata_i[B_ERR]) ctl_d.err = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ctl_q <= CTL_RST;
    else if (upd) ctl_q <= ctl_d;
  end

  always_comb begin
    rdata_o = 8'h00;
    case (addr_i)
      ADR_PWR: begin
        rdata_o[B_GLOB]  = ctl_q.glob_off;
        rdata_o[B_LATCH] = ctl_q.latch_hold;
        rdata_o[B_ADC]   = ctl_q.adc_off;
        rdata_o[B_PORT]  = ctl_q.port_off;
        rdata_o[B_PLL]   = ctl_q.pll_run;
        rdata_o[B_SPDIF] = ctl_q.spdif_off;
      end
      ADR_CFG: begin
        rdata_o[B_CLAMP] = ctl_q.clamp;
        rdata_o[B_OVR]   = ctl_q.override;
        rdata_o[B_PORT1] = ctl_q.port1_off;
        rdata_o[B_DEN]   = ctl_q.dac_en;
        rdata_o[B_AEN]   = ctl_q.adc_en;
      end
      ADR_STAT: begin
        rdata_o[B_DONE] = done_i;
        rdata_o[B_ERR]  = ctl_q.err;
        rdata_o[2]      = ctl_q.clamp;
      end
      default: ;
    endcase
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq #(
  parameter int unsigned DONE_CYC = 16,
  parameter int unsigned DIS_CYC  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic glob_off_i,
  input  logic clamp_i,
  output logic done_o,
  output logic disch_end_o
);
  localparam int DW = $clog2(DONE_CYC + 1);
  localparam int TW = $clog2(DIS_CYC + 1);
  localparam logic [DW-1:0] DONE_LAST = DW'(DONE_CYC);
  localparam logic [TW-1:0] DIS_LAST  = TW'(DIS_CYC - 1);

  logic [DW-1:0] dcnt_q, dcnt_d;
  logic          dcnt_en;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_en;

  always_comb begin
    dcnt_en = 1'b1;
    if (!glob_off_i)              dcnt_d = '0;
    else if (dcnt_q != DONE_LAST) dcnt_d = dcnt_q + 1'b1;
    else begin
      dcnt_d  = dcnt_q;
      dcnt_en = 1'b0;
    end
  end

  always_comb begin
    tmr_en      = clamp_i | (tmr_q != '0);
    disch_end_o = clamp_i && (tmr_q == DIS_LAST);
    if (!clamp_i || disch_end_o) tmr_d = '0;
    else                         tmr_d = tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dcnt_q <= '0;
    else if (dcnt_en) dcnt_q <= dcnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end

  assign done_o = glob_off_i && (dcnt_q == DONE_LAST);
endmodule

// File: rtl/pwr_src_sel.sv
module pwr_src_sel (
  input  logic glob_off_i,
  input  logic override_i,
  input  logic en_i,
  input  logic bypass_i,
  input  logic if_sel_i,
  input  logic port_en_i,
  output logic on_o
);
  always_comb begin
    if (glob_off_i)      on_o = 1'b0;
    else if (override_i) on_o = en_i;
    else if (bypass_i)   on_o = 1'b0;
    else if (if_sel_i)   on_o = 1'b1;
    else                 on_o = port_en_i;
  end
endmodule

// File: rtl/codec_pwr_ctl.sv
module codec_pwr_ctl
  import pwr_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 12_288_000,
  parameter int unsigned DISCHARGE_US = 46_000,
  parameter int unsigned DONE_CYC     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       bypass_dac_i,
  input  logic       bypass_adc_i,
  input  logic       if_sel_i,
  input  logic       sdin0_en_i,
  input  logic       sdout_en_i,
  output logic       adc_on_o,
  output logic       port_on_o,
  output logic       port1_on_o,
  output logic       dac_src_on_o,
  output logic       adc_src_on_o,
  output logic       pll_run_o,
  output logic       spdif_tx_off_o,
  output logic       clamp_o,
  output logic       done_o
);
  localparam int unsigned DIS_CYC = (CLK_HZ / 1000) * DISCHARGE_US / 1000;
  localparam int NSRC = 2;  // index 0: ADC converter, 1: DAC converter

  pwr_ctl_t  ctl;
  logic      glob_off, latch_hold, err_flag, disch_end;
  logic [NSRC-1:0] src_en, src_byp, src_port, src_on;

  pwr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .done_i(done_o), .disch_end_i(disch_end), .ctl_o(ctl), .rdata_o(rdata_o)
  );

  pwr_seq #(.DONE_CYC(DONE_CYC), .DIS_CYC(DIS_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .glob_off_i(glob_off), .clamp_i(ctl.clamp),
    .done_o(done_o), .disch_end_o(disch_end)
  );

  assign glob_off   = ctl.glob_off;
  assign latch_hold = ctl.latch_hold;
  assign err_flag   = ctl.err;

  assign src_en   = {ctl.dac_en, ctl.adc_en};
  assign src_byp  = {bypass_dac_i, bypass_adc_i};
  assign src_port = {sdin0_en_i, sdout_en_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    pwr_src_sel u_sel (
      .glob_off_i(glob_off), .override_i(ctl.override), .en_i(src_en[g]),
      .bypass_i(src_byp[g]), .if_sel_i(if_sel_i), .port_en_i(src_port[g]),
      .on_o(src_on[g])
    );
  end

  assign adc_src_on_o   = src_on[0];
  assign dac_src_on_o   = src_on[1];
  assign adc_on_o       = !glob_off && !ctl.adc_off;
  assign port_on_o      = !glob_off && !ctl.port_off;
  assign port1_on_o     = port_on_o && !ctl.port1_off;
  assign pll_run_o      = ctl.pll_run;
  assign spdif_tx_off_o = ctl.spdif_off;
  assign clamp_o        = ctl.clamp && glob_off;
endmodule

// File: rtl/codec_pwr_chk.sv
module codec_pwr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       we_i,
  input logic [1:0] addr_i,
  input logic [7:0] wdata_i,
  input logic       glob_off,
  input logic       latch_hold,
  input logic       err_flag,
  input logic       adc_on_o,
  input logic       port_on_o,
  input logic       port1_on_o,
  input logic       dac_src_on_o,
  input logic       adc_src_on_o,
  input logic       clamp_o,
  input logic       done_o
);
  AST_GLOB_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    glob_off |-> !(adc_on_o || port_on_o || port1_on_o || dac_src_on_o || adc_src_on_o)); // R2

  AST_REFUSE_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == 2'd0 && wdata_i[0] && !glob_off && !latch_hold)
      |=> (!glob_off && err_flag)); // R3

  AST_DONE_NEEDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> glob_off); // R4

  AST_DONE_RISE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(glob_off)); // R4

  AST_CLAMP_ONLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_o |-> glob_off); // R9

  AST_PORT1_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !port_on_o |-> !port1_on_o); // R8
endmodule

bind codec_pwr_ctl codec_pwr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .glob_off(glob_off), .latch_hold(latch_hold), .err_flag(err_flag),
  .adc_on_o(adc_on_o), .port_on_o(port_on_o), .port1_on_o(port1_on_o),
  .dac_src_on_o(dac_src_on_o), .adc_src_on_o(adc_src_on_o),
  .clamp_o(clamp_o), .done_o(done_o)
);

// File: tb/test_codec_pwr_ctl.sv
`timescale 1ns/100ps
module test_codec_pwr_ctl;
  localparam int DONE_CYC = 5;
  localparam int DIS_CYC  = 40;
  localparam int NVEC     = 10;
  // {ovr, den, aen, byp_dac, byp_adc, if_sel, sdin0, sdout, exp_dac, exp_adc}
  localparam logic [9:0] VEC [NVEC] = '{
    10'b0000010011, 10'b0001010001, 10'b0000110010, 10'b0000001010,
    10'b0000000101, 10'b0000000000, 10'b0001001101, 10'b1101100010,
    10'b1010010001, 10'b1000011100 };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic bypass_dac_i = 1'b0, bypass_adc_i = 1'b0, if_sel_i = 1'b0;
  logic sdin0_en_i = 1'b0, sdout_en_i = 1'b0;
  logic [7:0] rdata_o;
  logic adc_on_o, port_on_o, port1_on_o, dac_src_on_o, adc_src_on_o;
  logic pll_run_o, spdif_tx_off_o, clamp_o, done_o;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  codec_pwr_ctl #(.CLK_HZ(1_000_000), .DISCHARGE_US(DIS_CYC), .DONE_CYC(DONE_CYC))
  i_codec_pwr_ctl (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr_i = a; #1;
    chk(tag, rdata_o, exp);
  endtask

  function automatic logic [7:0] outs();
    return {clamp_o, done_o, adc_on_o, port_on_o, port1_on_o, dac_src_on_o, adc_src_on_o, pll_run_o};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", outs(), 8'h00);
    chk("R1 spdif off in reset", {7'd0, spdif_tx_off_o}, 8'h01);
    rst_n = 1'b1;
    rd(2'd2, 8'h00, "R1 status");
    rd(2'd0, 8'h2D, "R1 loc0");
    rd(2'd1, 8'h04, "R1 loc1");

    // R2: blocks held off while globally off, pll/spdif follow own bits
    wr(2'd0, 8'h11);
    chk("R2 gated while off", {adc_on_o, port_on_o, pll_run_o, spdif_tx_off_o}, 8'h02);
    wr(2'd0, 8'h10);
    chk("R2 released", {adc_on_o, port_on_o, port1_on_o}, 8'h06);

    // R8: second port
    wr(2'd1, 8'h00);
    chk("R8 port1 on", {7'd0, port1_on_o}, 8'h01);
    wr(2'd0, 8'h18);
    chk("R8 port1 forced off", {port_on_o, port1_on_o}, 8'h00);
    rd(2'd1, 8'h00, "R8 own bit kept");
    wr(2'd0, 8'h10);

    // R5 R6 R7: converter priority table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {bypass_dac_i, bypass_adc_i, if_sel_i, sdin0_en_i, sdout_en_i} = VEC[i][6:2];
      wr(2'd1, {4'd0, VEC[i][9], 1'b0, VEC[i][8], VEC[i][7]});
      chk($sformatf("R5 R6 R7 vector %0d", i), {6'd0, dac_src_on_o, adc_src_on_o},
          {6'd0, VEC[i][1:0]});
    end

    // R3: refusal without latch
    if_sel_i = 1'b1;
    wr(2'd1, 8'h0B);
    wr(2'd0, 8'h11);
    chk("R3 refused keeps on", {adc_on_o, dac_src_on_o}, 8'h03);
    rd(2'd2, 8'h02, "R3 sticky error");
    wr(2'd2, 8'h02);
    rd(2'd2, 8'h00, "R3 error cleared");
    wr(2'd0, 8'h12);
    wr(2'd0, 8'h13);
    chk("R3 R2 accepted, all off", {adc_on_o, port_on_o, dac_src_on_o, adc_src_on_o, pll_run_o}, 8'h01);

    // R4: done timing
    repeat (DONE_CYC - 1) @(negedge clk);
    chk("R4 done not yet", {7'd0, done_o}, 8'h00);
    @(negedge clk);
    chk("R4 done raised", {7'd0, done_o}, 8'h01);

    // R9: clamp full window
    wr(2'd1, 8'h1B);
    chk("R9 clamp on", {7'd0, clamp_o}, 8'h01);
    repeat (DIS_CYC - 1) @(negedge clk);
    chk("R9 clamp last cycle", {7'd0, clamp_o}, 8'h01);
    @(negedge clk);
    chk("R9 clamp ended", {7'd0, clamp_o}, 8'h00);
    rd(2'd1, 8'h0B, "R9 clamp bit self-cleared");

    // R9 R4: early release
    wr(2'd1, 8'h1B);
    repeat (3) @(negedge clk);
    wr(2'd0, 8'h12);
    chk("R9 R4 release at once", {clamp_o, done_o}, 8'h00);
    rd(2'd1, 8'h0B, "R9 bit dropped");
    wr(2'd1, 8'h1B);
    chk("R9 ignored while on", {7'd0, clamp_o}, 8'h00);
    rd(2'd1, 8'h0B, "R9 bit not taken");

    // R10: reserved bits
    wr(2'd1, 8'hEB);
    rd(2'd1, 8'h0B, "R10 loc1 reserved");
    wr(2'd0, 8'hD2);
    rd(2'd0, 8'h12, "R10 loc0 reserved");
    rd(2'd3, 8'h00, "R10 loc3");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule